// File: doc/BRIEF.md
# Time-Difference Sign-Magnitude Digitizer

This block turns the arrival-time gap between two asynchronous completion signals into a signed digital word. One input marks the end of the chain that adds up the positive terms of a measurement row, the other the end of the chain that adds up the negative terms. Each chain signals completion with a falling edge. The difference of the two sums is therefore carried by the time between those edges.

Both inputs pass through a synchronizer into the reference clock domain. A sticky capture flag per chain records its falling edge. The exclusive-OR of the two flags forms a result pulse that spans from the first capture to the second. A counter clocked by the reference clock measures the width of that pulse. A set/reset style flag records whether the negative chain was the later one, and that flag becomes the sign.

When the second capture lands, the block emits a one-cycle strobe with the sign-magnitude word. The same strobe clears the captures so the next measurement row can start. The subtraction is done in time, and no digital subtractor is used.

Top module: `tdd_top`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `result_word`, `result_valid`, `row_trig` and `result_pulse` are all 0.
- R2: The magnitude `result_word[7:0]` equals the number of reference clock cycles between the sampled falling edges of the two chain inputs. The strobe appears on the fourth rising clock edge that samples the later falling edge (two synchronizer stages, one capture stage, one output stage).
- R3: `result_word[8]` (sign) is 1 when the negative-term chain's falling edge is the later one, and 0 when the positive-term chain's falling edge is the later one.
- R4: When both falling edges are sampled in the same reference cycle, the word is sign 0 and magnitude 0, and a strobe is still produced.
- R5: A gap longer than 255 cycles gives magnitude 255 (saturation, no wrap).
- R6: `result_valid` and `row_trig` are high together for exactly one cycle per measurement. `result_word` holds its value until the next strobe.
- R7: `result_pulse` is high from the cycle after the first capture until the second capture, and low otherwise.
- R8: Further edges on a chain input that has already been captured are ignored until the row trigger. The gap is measured from that chain's first falling edge.
- R9: The strobe clears both captures, the sign flag and the counter, so consecutive rows are measured independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_chain_end | input | 1 | Asynchronous completion signal of the positive-term chain, completion on falling edge |
| neg_chain_end | input | 1 | Asynchronous completion signal of the negative-term chain, completion on falling edge |
| result_pulse | output | 1 | Exclusive-OR of the two capture flags |
| result_word | output | 9 | Bit 8 sign, bits 7:0 magnitude in reference cycles |
| result_valid | output | 1 | One-cycle strobe when a new word is loaded |
| row_trig | output | 1 | One-cycle trigger for the next measurement row |

## Verification
The bench builds the block with its defaults: an 8-bit magnitude and two synchronizer stages. The 8-bit width puts saturation within reach of a 300-cycle gap, which keeps the run short. The two-stage synchronizer fixes the strobe latency at four sampling edges after the later edge, and the bench checks against that count. The vector table covers both arrival orders and gaps of 0, 1 and several cycles. Directed cases then cover saturation, a bouncing input that has already been captured, the pulse shape, holding the word between strobes, and reset in the middle of a row.

// File: rtl/tdd_pkg.sv
// Package: shared chain indices and the saturating increment used by the
// width counter. Assumes magnitudes of at most 16 bits.
package tdd_pkg;

    typedef enum logic {
        CH_POS = 1'b0,
        CH_NEG = 1'b1
    } chain_e;

    localparam int NUM_CHAINS = 2;

    // Saturating increment against an all-ones limit.
    function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] lim);
        return (v >= lim) ? lim : v + 16'd1;
    endfunction

endpackage

// File: rtl/tdd_edge_sync.sv
// Module: tdd_edge_sync
// Brings one asynchronous chain-completion signal into the reference clock
// domain and flags a falling edge for one cycle.
// Assumes the signal idles high, so the stages reset to 1 and a low input
// held through reset is reported as a fall after release.
module tdd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] stage_q;

    // Shift register: stages 0..STAGES-1 synchronize, stage STAGES keeps the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[LAST-1:0], async_in};
        end
    end

    // Falling edge: the previous sample was high and the current sample is low.
    always_comb begin
        fall = stage_q[LAST] & ~stage_q[LAST-1];
    end

endmodule

// File: rtl/tdd_capture.sv
// Module: tdd_capture
// Per-chain sticky capture flags, modelled on a negative-edge flop with D
// tied high, plus the sign flag. The sign flag is set when the negative
// chain is captured while the positive chain is already captured. An edge
// in the same cycle as clear is dropped, so clear takes priority.
module tdd_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pos_fall,
    input  logic neg_fall,
    output logic pos_cap,
    output logic neg_cap,
    output logic sign_q,
    output logic pulse,
    output logic both
);
    // Sticky capture of each chain's first falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos_cap <= 1'b0;
            neg_cap <= 1'b0;
        end else begin
            pos_cap <= pos_cap | pos_fall;
            neg_cap <= neg_cap | neg_fall;
        end
    end

    // Sign flag: set when the negative chain finishes strictly later than the positive chain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sign_q <= 1'b0;
        end else if (neg_fall && pos_cap && !neg_cap) begin
            sign_q <= 1'b1;
        end
    end

    // Result pulse and the both-captured condition.
    always_comb begin
        pulse = pos_cap ^ neg_cap;
        both  = pos_cap & neg_cap;
    end

endmodule

// File: rtl/tdd_width_counter.sv
// Module: tdd_width_counter
// Counts the reference cycles in which the result pulse is high and
// saturates at the all-ones value of MAG_W bits. A clear overrides counting.
module tdd_width_counter
    import tdd_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [MAG_W-1:0] cnt
);
    localparam logic [15:0] LIMIT = 16'((1 << MAG_W) - 1);

    logic [15:0] next_wide;

    // Saturating increment, computed in the package width.
    always_comb begin
        next_wide = sat_inc(16'(cnt), LIMIT);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= next_wide[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/tdd_top.sv
// Module: tdd_top
// Time-difference sign-magnitude digitizer. Synchronizes the two chain
// completion signals, captures their falling edges and measures the XOR
// pulse. When both chains are captured it loads {sign, magnitude} into the
// output word, strobes valid and the row trigger, and clears the captures.
// Assumes both chain inputs are high again before the next row's edges.
module tdd_top
    import tdd_pkg::*;
#(
    parameter int MAG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pos_chain_end,
    input  logic           neg_chain_end,
    output logic           result_pulse,
    output logic [MAG_W:0] result_word,
    output logic           result_valid,
    output logic           row_trig
);
    localparam int WORD_W = MAG_W + 1;

    logic [NUM_CHAINS-1:0] chain_in;
    logic [NUM_CHAINS-1:0] chain_fall;
    logic                  pos_cap;
    logic                  neg_cap;
    logic                  sign_q;
    logic                  both;
    logic [MAG_W-1:0]      cnt_q;
    logic                  done_q;
    logic [WORD_W-1:0]     word_q;

    // Chain inputs gathered by index.
    always_comb begin
        chain_in[CH_POS] = pos_chain_end;
        chain_in[CH_NEG] = neg_chain_end;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CHAINS; gi++) begin : g_sync
            tdd_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (chain_in[gi]),
                .fall     (chain_fall[gi])
            );
        end
    endgenerate

    tdd_capture cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (both),
        .pos_fall (chain_fall[CH_POS]),
        .neg_fall (chain_fall[CH_NEG]),
        .pos_cap  (pos_cap),
        .neg_cap  (neg_cap),
        .sign_q   (sign_q),
        .pulse    (result_pulse),
        .both     (both)
    );

    tdd_width_counter #(.MAG_W(MAG_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (both),
        .en    (result_pulse),
        .cnt   (cnt_q)
    );

    // Output stage: load the word and raise the one-cycle strobe when both chains are in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= both;
            if (both) begin
                word_q <= {sign_q, cnt_q};
            end
        end
    end

    // Port drive.
    always_comb begin
        result_word  = word_q;
        result_valid = done_q;
        row_trig     = done_q;
    end

endmodule

// File: rtl/tdd_checker.sv
// Module: tdd_checker
// Assertions on the digitizer, attached to tdd_top by bind.
module tdd_checker #(
    parameter int MAG_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [MAG_W:0] result_word,
    input logic           result_valid,
    input logic           pos_cap,
    input logic           neg_cap,
    input logic           both,
    input logic [MAG_W-1:0] cnt_q
);
    localparam logic [MAG_W-1:0] CNT_MAX = '1;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result_word));

    assert_zero_gap_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result_word[MAG_W-1:0] == '0) |-> !result_word[MAG_W]);

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !both) |=> cnt_q == CNT_MAX);

    assert_caps_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (!pos_cap && !neg_cap));

endmodule

bind tdd_top tdd_checker #(.MAG_W(MAG_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_word  (result_word),
    .result_valid (result_valid),
    .pos_cap      (pos_cap),
    .neg_cap      (neg_cap),
    .both         (both),
    .cnt_q        (cnt_q)
);

// File: tb/tdd_top_tb_top.sv
module tdd_top_tb_top;
    localparam int MAG_W = 8;
    localparam int NV    = 6;
    // Vector: bit 9 = negative chain falls first, bits 8:0 = gap in cycles.
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 9'd5}, {1'b1, 9'd5}, {1'b0, 9'd1},
        {1'b1, 9'd17}, {1'b0, 9'd0}, {1'b1, 9'd40}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_in = 1'b1;
    logic neg_in = 1'b1;
    logic pulse;
    logic [MAG_W:0] word;
    logic valid;
    logic trig;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tdd_top #(.MAG_W(MAG_W), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pos_chain_end (pos_in),
        .neg_chain_end (neg_in),
        .result_pulse  (pulse),
        .result_word   (word),
        .result_valid  (valid),
        .row_trig      (trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MAG_W:0] expect_word(input bit neg_first, input int gap);
        logic [MAG_W-1:0] m;
        m = (gap > 255) ? 8'd255 : 8'(gap);
        return {(!neg_first && gap > 0), m};
    endfunction

    // Re-arm both inputs high and let the synchronizers settle.
    task automatic rearm();
        @(negedge clk);
        pos_in = 1'b1;
        neg_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Run one row and check strobe timing and word (R2, R3, R6).
    task automatic run_row(input bit neg_first, input int gap, input string req);
        rearm();
        if (gap == 0) begin
            pos_in = 1'b0;
            neg_in = 1'b0;
        end else begin
            if (neg_first) neg_in = 1'b0; else pos_in = 1'b0;
            repeat (gap) @(negedge clk);
            if (neg_first) pos_in = 1'b0; else neg_in = 1'b0;
        end
        repeat (3) @(negedge clk);
        check({req, " no early strobe R2"}, 32'(valid), 32'd0);
        @(negedge clk);
        check({req, " strobe R2"}, 32'(valid), 32'd1);
        check({req, " trig R6"}, 32'(trig), 32'd1);
        check({req, " word R2 R3"}, 32'(word), 32'(expect_word(neg_first, gap)));
        @(negedge clk);
        check({req, " single strobe R6"}, 32'(valid), 32'd0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 word", 32'(word), 32'd0);
        check("R1 valid", 32'(valid), 32'd0);
        check("R1 pulse", 32'(pulse), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", 32'({valid, trig, pulse}), 32'd0);

        // Vector table: R2, R3, R4, R9 (rows back to back)
        for (int i = 0; i < NV; i++) begin
            run_row(VEC[i][9], int'(VEC[i][8:0]), $sformatf("vec%0d R9", i));
        end

        // R4: explicit simultaneous edges
        run_row(1'b1, 0, "R4 simultaneous");
        check("R4 word", 32'(word), 32'd0);

        // R5: saturation
        run_row(1'b0, 300, "R5 saturate");
        check("R5 magnitude", 32'(word[7:0]), 32'd255);

        // R6: word held between strobes
        repeat (10) @(negedge clk);
        check("R6 hold word", 32'(word), 32'(expect_word(1'b0, 300)));
        check("R6 no strobe", 32'(valid), 32'd0);

        // R7 + R8: pulse shape and a bouncing captured input
        rearm();
        pos_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 pulse high", 32'(pulse), 32'd1);
        pos_in = 1'b1;
        repeat (2) @(negedge clk);
        pos_in = 1'b0;
        repeat (7) @(negedge clk);
        check("R7 pulse still high", 32'(pulse), 32'd1);
        neg_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 pulse low after second capture", 32'(pulse), 32'd0);
        @(negedge clk);
        check("R8 strobe", 32'(valid), 32'd1);
        check("R8 word from first edge", 32'(word), 32'(expect_word(1'b0, 12)));

        // R1: reset in the middle of a row
        rearm();
        neg_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        pos_in = 1'b1;
        neg_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mid-row word", 32'(word), 32'd0);
        check("R1 mid-row pulse", 32'(pulse), 32'd0);
        rst_n = 1'b1;
        run_row(1'b0, 9, "R1 R9 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule